// File: doc/BRIEF.md
# CAM-Tag Banked Cache

This block is an 8 KB cache for a processor's load/store path. It is built from eight independent 1 KB sub-banks. Three address bits select one sub-bank, and only that sub-bank searches its tags. Each sub-bank is fully associative. It holds 32 lines of 32 bytes, and its 32 tags are compared with the request tag in parallel. The cache is therefore 32-way associative. The hit flag comes directly from the tag match. The data array is touched only for the matching line, so a store hit completes in one cycle and needs no write buffer.

The processor issues one request per cycle while `req_ready_o` is high. A response follows one cycle later: `rsp_valid_o`, the hit flag and, for a load hit, the addressed word. A load miss raises `miss_req_o` with the line-aligned address. The cache then takes eight refill words, in word order, on the refill port. After the last word it installs the tag and accepts requests again. A store miss changes nothing. The replaced line is the lowest-numbered invalid entry of the sub-bank. If the sub-bank has no invalid entry, a per-sub-bank rotating pointer selects the line.

Top module: `cam_cache`

## Requirements
- R1: Address fields, from the top bit down: tag is bits [31:8], sub-bank select is bits [7:5], word within line is bits [4:2], and byte bits [1:0] are ignored. Store byte lanes come only from `req_be_i`.
- R2: An accepted request enables exactly one sub-bank, chosen by the sub-bank select bits. A line held in one sub-bank never produces a hit for an address that selects another sub-bank.
- R3: Each sub-bank holds 32 lines with distinct tags at the same time, and any of them can hit.
- R4: A hit needs a valid entry whose tag is equal to the request tag. Reset clears every valid bit, so after reset every access misses, `req_ready_o` is 1, and `rsp_valid_o` and `miss_req_o` are 0.
- R5: In the cycle after an accepted request, `rsp_valid_o` is 1 and `rsp_hit_o` gives the result. `rsp_rdata_o` holds the addressed word on a load hit and 0 otherwise. Outside that cycle `rsp_valid_o` is 0.
- R6: A store hit writes only the byte lanes whose `req_be_i` bit is set (bit n covers data bits 8n+7:8n), in the same cycle and with no refill. A store miss writes nothing and raises no miss request.
- R7: A load miss raises `miss_req_o` in the next cycle, with `miss_addr_o` equal to the request address with bits [4:0] cleared. `req_ready_o` stays 0 until eight refill words have been accepted. The k-th accepted word becomes word k of the line. The cycle after the eighth word, `req_ready_o` is 1 and `miss_req_o` is 0.
- R8: The refilled entry is the lowest-numbered invalid entry of the sub-bank. When the sub-bank has no invalid entry, the entry is the one at the sub-bank's pointer. Reset sets each pointer to 0, and a pointer advances by one (modulo 32) after every refill of its sub-bank.
- R9: At most one entry of the enabled sub-bank matches a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Cache accepts a request this cycle |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Store data |
| req_be_i | input | 4 | Store byte enables |
| rsp_valid_o | output | 1 | Response for the request of the previous cycle |
| rsp_hit_o | output | 1 | Request hit |
| rsp_rdata_o | output | 32 | Load data on a hit, else 0 |
| miss_req_o | output | 1 | Line refill outstanding |
| miss_addr_o | output | 32 | Line-aligned address to refill |
| refill_valid_i | input | 1 | Refill word present |
| refill_data_i | input | 32 | Refill word |

## Verification
The bound checker watches the cycle-level rules on every cycle. It checks that at most one tag matches, that one sub-bank is enabled per accepted request, that the response comes one cycle after acceptance, that a miss request follows only a load and blocks new requests, and that the miss address is line aligned. Other behaviour depends on what the cache holds, so only the bench's scenarios can show it. This covers byte-lane merging on store hits, store misses that leave memory untouched, sub-bank isolation of equal tags, and refill word order. It also covers the lowest-invalid-first fill of all 32 entries, the rotating eviction once a sub-bank is full, and the loss of every line at reset. These are checked against a behavioural model.

// File: rtl/cam_cache_pkg.sv
package cam_cache_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fill_state_e;
endpackage

// File: rtl/cam_bank.sv
module cam_bank #(
  parameter int WAYS  = 32,
  parameter int TAG_W = 24,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             search_en_i,
  input  logic [TAG_W-1:0] search_tag_i,
  input  logic             wr_en_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  output logic [WAYS-1:0]  match_o,
  output logic [WAYS-1:0]  valid_o
);
  logic [TAG_W-1:0] tag_q [WAYS];
  logic [WAYS-1:0]  valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_way_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_way_i] <= wr_tag_i;
  end

  // parallel compare, gated by bank enable
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = search_en_i & valid_q[w] & (tag_q[w] == search_tag_i);
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/victim_sel.sv
module victim_sel #(
  parameter int WAYS  = 32,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WAYS-1:0]  valid_i,
  input  logic             advance_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [WAY_W-1:0] ptr_q;
  logic [WAY_W-1:0] free_way;
  logic             free_found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (advance_i) ptr_q <= (ptr_q == WAY_W'(WAYS-1)) ? '0 : ptr_q + 1'b1;
  end

  // descending scan leaves the lowest invalid way
  always_comb begin
    free_way   = '0;
    free_found = 1'b0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        free_way   = WAY_W'(w);
        free_found = 1'b1;
      end
    end
  end

  assign victim_o = free_found ? free_way : ptr_q;
endmodule

// File: rtl/line_store.sv
module line_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2048,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int BE_W   = DATA_W/8
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BE_W-1:0]   wr_be_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int b = 0; b < BE_W; b++) begin
        if (wr_be_i[b]) mem_q[wr_idx_i][b*8 +: 8] <= wr_data_i[b*8 +: 8];
      end
    end
    rd_data_o <= rd_en_i ? mem_q[rd_idx_i] : '0;
  end
endmodule

// File: rtl/cam_cache.sv
module cam_cache
  import cam_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_BANKS  = 8,
  parameter int WAYS       = 32,
  parameter int LINE_WORDS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W/8-1:0] req_be_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              miss_req_o,
  output logic [ADDR_W-1:0] miss_addr_o,
  input  logic              refill_valid_i,
  input  logic [DATA_W-1:0] refill_data_i
);
  localparam int BE_W   = DATA_W/8;
  localparam int BYTE_W = $clog2(BE_W);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int OFF_W  = BYTE_W + WORD_W;
  localparam int TAG_W  = ADDR_W - BANK_W - OFF_W;
  localparam int IDX_W  = BANK_W + WAY_W + WORD_W;
  localparam int DEPTH  = NUM_BANKS * WAYS * LINE_WORDS;

  fill_state_e       state_q;
  logic [TAG_W-1:0]  fill_tag_q;
  logic [BANK_W-1:0] fill_bank_q;
  logic [WAY_W-1:0]  fill_way_q;
  logic [WORD_W-1:0] fill_cnt_q;

  logic [TAG_W-1:0]  req_tag;
  logic [BANK_W-1:0] req_bank;
  logic [WORD_W-1:0] req_word;
  logic              req_fire;
  logic [NUM_BANKS-1:0] bank_en;
  logic [WAYS-1:0]   match_all  [NUM_BANKS];
  logic [WAYS-1:0]   valid_all  [NUM_BANKS];
  logic [WAY_W-1:0]  victim_all [NUM_BANKS];
  logic [WAYS-1:0]   sel_match;
  logic [WAY_W-1:0]  hit_way;
  logic              hit;
  logic              store_hit, load_hit, load_miss;
  logic              fill_we, fill_done;
  logic              rsp_valid_q, rsp_hit_q;
  logic [DATA_W-1:0] rd_data;
  logic              unused_byte_bits;

  assign req_tag  = req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_bank = req_addr_i[OFF_W +: BANK_W];
  assign req_word = req_addr_i[BYTE_W +: WORD_W];
  assign unused_byte_bits = ^req_addr_i[BYTE_W-1:0];

  assign req_ready_o = (state_q == ST_IDLE);
  assign req_fire    = req_valid_i & req_ready_o;
  assign bank_en     = req_fire ? (NUM_BANKS'(1) << req_bank) : '0;

  assign fill_we   = (state_q == ST_FILL) & refill_valid_i;
  assign fill_done = fill_we & (fill_cnt_q == WORD_W'(LINE_WORDS-1));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic install;
    assign install = fill_done & (fill_bank_q == BANK_W'(b));

    cam_bank #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_cam (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .search_en_i  (bank_en[b]),
      .search_tag_i (req_tag),
      .wr_en_i      (install),
      .wr_way_i     (fill_way_q),
      .wr_tag_i     (fill_tag_q),
      .match_o      (match_all[b]),
      .valid_o      (valid_all[b])
    );

    victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (valid_all[b]),
      .advance_i (install),
      .victim_o  (victim_all[b])
    );
  end

  assign sel_match = match_all[req_bank];
  assign hit       = |sel_match;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (sel_match[w]) hit_way = WAY_W'(w);
    end
  end

  assign store_hit = req_fire &  req_write_i &  hit;
  assign load_hit  = req_fire & ~req_write_i &  hit;
  assign load_miss = req_fire & ~req_write_i & ~hit;

  line_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .BE_W(BE_W)) u_data (
    .clk_i     (clk_i),
    .wr_en_i   (store_hit | fill_we),
    .wr_idx_i  (fill_we ? {fill_bank_q, fill_way_q, fill_cnt_q} : {req_bank, hit_way, req_word}),
    .wr_data_i (fill_we ? refill_data_i : req_wdata_i),
    .wr_be_i   (fill_we ? {BE_W{1'b1}} : req_be_i),
    .rd_en_i   (load_hit),
    .rd_idx_i  ({req_bank, hit_way, req_word}),
    .rd_data_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      fill_tag_q  <= '0;
      fill_bank_q <= '0;
      fill_way_q  <= '0;
      fill_cnt_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (load_miss) begin
          state_q     <= ST_FILL;
          fill_tag_q  <= req_tag;
          fill_bank_q <= req_bank;
          fill_way_q  <= victim_all[req_bank];
          fill_cnt_q  <= '0;
        end
        ST_FILL: if (fill_we) begin
          fill_cnt_q <= fill_cnt_q + 1'b1;
          if (fill_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      rsp_valid_q <= req_fire;
      rsp_hit_q   <= req_fire & hit;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_rdata_o = rsp_hit_q ? rd_data : '0;
  assign miss_req_o  = (state_q == ST_FILL);
  assign miss_addr_o = {fill_tag_q, fill_bank_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/cam_cache_chk.sv
module cam_cache_chk #(
  parameter int NUM_BANKS = 8,
  parameter int WAYS      = 32,
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_fire_i,
  input logic                 req_write_i,
  input logic [NUM_BANKS-1:0] bank_en_i,
  input logic [WAYS-1:0]      sel_match_i,
  input logic                 rsp_valid_i,
  input logic                 rsp_hit_i,
  input logic                 miss_req_i,
  input logic                 req_ready_i,
  input logic [ADDR_W-1:0]    miss_addr_i
);
  assert_single_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_match_i));

  assert_one_bank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_fire_i |-> $countones(bank_en_i) == 1);

  assert_idle_banks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_fire_i |-> bank_en_i == '0);

  assert_rsp_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_fire_i |=> rsp_valid_i);

  assert_no_stray_rsp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_fire_i |=> !rsp_valid_i);

  assert_hit_in_rsp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_i |-> rsp_valid_i);

  assert_miss_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_req_i |-> !req_ready_i);

  assert_miss_aligned_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_req_i |-> miss_addr_i[OFF_W-1:0] == '0);

  assert_store_no_refill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_fire_i && req_write_i) |=> !miss_req_i);

  assert_miss_from_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(miss_req_i) |-> $past(req_fire_i && !req_write_i));
endmodule

bind cam_cache cam_cache_chk #(
  .NUM_BANKS (NUM_BANKS),
  .WAYS      (WAYS),
  .ADDR_W    (ADDR_W),
  .OFF_W     (OFF_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_fire_i  (req_fire),
  .req_write_i (req_write_i),
  .bank_en_i   (bank_en),
  .sel_match_i (sel_match),
  .rsp_valid_i (rsp_valid_o),
  .rsp_hit_i   (rsp_hit_o),
  .miss_req_i  (miss_req_o),
  .req_ready_i (req_ready_o),
  .miss_addr_i (miss_addr_o)
);

// File: tb/cam_cache_tb.sv
module cam_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_rdata;
  logic        miss_req;
  logic [31:0] miss_addr;
  logic        refill_valid = 1'b0;
  logic [31:0] refill_data = '0;

  always #10 clk = ~clk;

  cam_cache dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_rdata_o(rsp_rdata),
    .miss_req_o(miss_req), .miss_addr_o(miss_addr),
    .refill_valid_i(refill_valid), .refill_data_i(refill_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural model
  logic [23:0] m_tag [8][32];
  bit          m_val [8][32];
  logic [31:0] m_dat [8][32][8];
  int          m_ptr [8];

  task automatic chk(input bit ok, input string req, input string ctx,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s) actual=%h expected=%h", req, ctx, act, exp);
    end
  endtask

  function automatic logic [31:0] backing(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] mk(input int tag, input int bank, input int word);
    return {tag[23:0], bank[2:0], word[2:0], 2'b00};
  endfunction

  task automatic m_clear();
    for (int b = 0; b < 8; b++) begin
      m_ptr[b] = 0;
      for (int w = 0; w < 32; w++) m_val[b][w] = 1'b0;
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input string ctx);
    int bk = int'(a[7:5]);
    int wi = int'(a[4:2]);
    logic [23:0] tg = a[31:8];
    int hw = -1;
    bit exp_hit;
    logic [31:0] exp_rd;
    for (int w = 0; w < 32; w++) if (m_val[bk][w] && m_tag[bk][w] == tg) hw = w;
    exp_hit = (hw >= 0);
    exp_rd  = (!wr && exp_hit) ? m_dat[bk][hw][wi] : 32'h0;

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R5", ctx, 32'(rsp_valid), 32'h1);
    chk(rsp_hit == exp_hit, "R5", ctx, 32'(rsp_hit), 32'(exp_hit));
    chk(rsp_rdata == exp_rd, "R5", ctx, rsp_rdata, exp_rd);
    chk(miss_req == (!wr && !exp_hit), "R7", ctx, 32'(miss_req), 32'(!wr && !exp_hit));

    if (wr && exp_hit) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) m_dat[bk][hw][wi][b*8 +: 8] = wd[b*8 +: 8];
    end

    if (!wr && !exp_hit) begin
      int v = -1;
      logic [31:0] line = {a[31:5], 5'b0};
      chk(miss_addr == line, "R7", ctx, miss_addr, line);
      chk(req_ready == 1'b0, "R7", ctx, 32'(req_ready), 32'h0);
      for (int w = 31; w >= 0; w--) if (!m_val[bk][w]) v = w;
      if (v < 0) v = m_ptr[bk];
      for (int k = 0; k < 8; k++) begin
        if (k % 3 == 1) begin
          @(negedge clk);
          chk(miss_req == 1'b1, "R7", "gap in refill", 32'(miss_req), 32'h1);
        end
        refill_valid = 1'b1;
        refill_data  = backing(line + 32'(4*k));
        m_dat[bk][v][k] = refill_data;
        @(negedge clk);
        refill_valid = 1'b0;
      end
      chk(req_ready == 1'b1, "R7", "after refill", 32'(req_ready), 32'h1);
      chk(miss_req == 1'b0, "R7", "after refill", 32'(miss_req), 32'h0);
      m_tag[bk][v] = tg;
      m_val[bk][v] = 1'b1;
      m_ptr[bk] = (m_ptr[bk] + 1) % 32;
    end else begin
      chk(req_ready == 1'b1, "R5", ctx, 32'(req_ready), 32'h1);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    m_clear();
    @(negedge clk);
    chk(req_ready == 1'b1, "R4", "reset ready", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R4", "reset rsp", 32'(rsp_valid), 32'h0);
    chk(miss_req == 1'b0, "R4", "reset miss", 32'(miss_req), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    do_reset();

    // R7 / R1: miss, refill, then every word of the line in order
    access(1'b0, mk('h111, 0, 3), '0, '0, "R7 first load miss");
    for (int k = 0; k < 8; k++) access(1'b0, mk('h111, 0, k), '0, '0, "R1 word select");
    access(1'b0, mk('h111, 0, 6) | 32'h3, '0, '0, "R1 byte bits ignored");

    // R6: byte-enable merge on a store hit, byte bits of the address ignored
    access(1'b1, mk('h111, 0, 3) | 32'h3, 32'hAABB_CCDD, 4'b0101, "R6 store hit");
    access(1'b0, mk('h111, 0, 3), '0, '0, "R6 merged readback");
    access(1'b1, mk('h111, 0, 3), 32'h1122_3344, 4'b0000, "R6 no lanes");
    access(1'b0, mk('h111, 0, 3), '0, '0, "R6 unchanged");

    // R6: store miss leaves nothing behind
    access(1'b1, mk('h222, 0, 1), 32'hDEAD_BEEF, 4'b1111, "R6 store miss");
    access(1'b0, mk('h222, 0, 1), '0, '0, "R6 load after store miss");

    // R2: same tag, other bank misses; original still hits
    access(1'b0, mk('h111, 1, 3), '0, '0, "R2 other bank");
    access(1'b0, mk('h111, 0, 3), '0, '0, "R2 home bank");

    // R3 / R8: fill bank 5 lowest-invalid first, all 32 resident
    for (int i = 0; i < 32; i++) access(1'b0, mk('h300 + i, 5, i % 8), '0, '0, "R8 fill");
    for (int i = 0; i < 32; i++) access(1'b0, mk('h300 + i, 5, 7 - i % 8), '0, '0, "R3 R9 all resident");

    // R8: rotating eviction once full
    access(1'b0, mk('h400, 5, 2), '0, '0, "R8 evict via pointer");
    access(1'b0, mk('h300, 5, 2), '0, '0, "R8 oldest gone");
    access(1'b0, mk('h302, 5, 2), '0, '0, "R8 survivor");
    access(1'b0, mk('h301, 5, 2), '0, '0, "R8 next victim");
    access(1'b0, mk('h400, 5, 0), '0, '0, "R8 newest kept");

    // R4: reset drops everything
    do_reset();
    access(1'b0, mk('h111, 0, 3), '0, '0, "R4 miss after reset");
    access(1'b0, mk('h302, 5, 2), '0, '0, "R4 miss after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule